// File: doc/BRIEF.md
# Overlapping Windowed Register File

This block holds the integer register state of a processor that gives each subroutine a fresh register window. The windows form a ring. Each window owns eight private locals and sees eight shared globals, and its eight outs are the same storage as the eight ins of the window one step lower in the ring. A caller leaves arguments in its outs; after a save the callee finds them in its ins. No data moves on save or restore; only the current window pointer changes.

A save moves the pointer down by one and a restore moves it up by one, both modulo the window count. An invalid-window mask, one bit per window with 1 meaning invalid, guards the ring. A save or restore whose target window is marked invalid does not move the pointer. The block then raises a one-cycle overflow or underflow flag, with the target window index, so that trap software can spill or fill that window. In normal use exactly one mask bit is set. Two read ports and one write port address registers by a 5-bit architectural number relative to the current window.

Top module: `win_regfile`

## Requirements
- R1: A save with restore low, whose target window (pointer minus one, modulo NWIN) has its mask bit clear, sets the pointer to that target on the next clock edge.
- R2: A restore with save low, whose target window (pointer plus one, modulo NWIN) has its mask bit clear, sets the pointer to that target on the next clock edge.
- R3: Save and restore asserted in the same cycle change nothing: the pointer holds and neither trap flag rises.
- R4: A save whose target window has its mask bit set leaves the pointer unchanged. On the next edge `ovf_o` is high for one cycle, with `trap_win_o` equal to the target window.
- R5: A restore whose target window has its mask bit set leaves the pointer unchanged. On the next edge `unf_o` is high for one cycle, with `trap_win_o` equal to the target window. `ovf_o` and `unf_o` are never high together.
- R6: Architectural numbers 0-7 select the eight globals, and these are the same storage in every window. 8-15 select the outs, 16-23 the locals and 24-31 the ins.
- R7: Register 0 always reads as zero, and a write to it is discarded.
- R8: Out register k of window N is the same storage as in register k of window (N-1) mod NWIN.
- R9: The locals of a window are private to it: a write to a local in one window is not seen in any other window.
- R10: Reads are combinational from stored state. A read of a register written in the same cycle returns the old value, and the new value is readable after the edge.
- R11: After reset the pointer is NWIN-1, the mask holds only bit 0, both trap flags are low and every register reads zero.
- R12: A mask write takes effect on the next clock edge. A save or restore in the same cycle is checked against the old mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| save_i | input | 1 | Request a window save (pointer down) |
| restore_i | input | 1 | Request a window restore (pointer up) |
| rd_a_addr | input | 5 | Read port A architectural register number |
| rd_a_data | output | DW | Read port A data |
| rd_b_addr | input | 5 | Read port B architectural register number |
| rd_b_data | output | DW | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write architectural register number |
| wr_data | input | DW | Write data |
| mask_wr_en | input | 1 | Load the invalid-window mask |
| mask_wr_data | input | NWIN | New invalid-window mask, bit i for window i |
| cwp_o | output | log2(NWIN) | Current window pointer |
| ovf_o | output | 1 | Window overflow trap pulse |
| unf_o | output | 1 | Window underflow trap pulse |
| trap_win_o | output | log2(NWIN) | Window index that caused the trap |

## Verification
The assertions check on every cycle how the pointer moves on save and restore. They also check that a trap fires exactly when the target is invalid and freezes the pointer, that both strobes together do nothing, that the two trap flags are exclusive, and that register 0 reads zero. Register aliasing cannot be seen from the control signals alone, so the bench scenarios cover it: globals shared across windows, outs reappearing as the ins of the next window after a save, locals staying private, and write-then-read timing. The bench does this with a full write-and-read sweep of every register in every window, checked against a bench-side model. The ordering between a mask write and a save in the same cycle is also shown only by a bench scenario.

// File: rtl/wrf_pkg.sv
// Shared definitions for the windowed register file.
// Assumes 5-bit architectural register numbers split into four groups of eight.
package wrf_pkg;
    localparam int unsigned GROUP_SIZE = 8;

    typedef enum logic [1:0] {
        GRP_GLOBAL = 2'd0,
        GRP_OUT    = 2'd1,
        GRP_LOCAL  = 2'd2,
        GRP_IN     = 2'd3
    } reg_group_e;

    // Group of an architectural register number (upper two bits).
    function automatic reg_group_e arch_group(input logic [4:0] arch);
        return reg_group_e'(arch[4:3]);
    endfunction
endpackage

// File: rtl/wrf_addr_map.sv
// Maps an architectural register number plus the current window to a flat
// physical index. Layout: globals at 0..7, locals at 8 + w*8 + k, shared
// in/out banks at 8 + NWIN*8 + b*8 + k. Window w uses bank w for its ins
// and bank (w-1) mod NWIN for its outs. Assumes NWIN is a power of two >= 2.
module wrf_addr_map
    import wrf_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int CW   = 3,
    parameter int PAW  = 8
) (
    input  logic [CW-1:0]  cwp,
    input  logic [4:0]     arch_addr,
    output logic [PAW-1:0] phys_idx
);
    localparam int LOC_BASE  = GROUP_SIZE;
    localparam int BANK_BASE = GROUP_SIZE + NWIN * GROUP_SIZE;

    logic [CW-1:0] out_bank;
    assign out_bank = cwp - CW'(1);

    // Select the physical slot for the register group addressed.
    always_comb begin
        unique case (arch_group(arch_addr))
            GRP_GLOBAL: phys_idx = PAW'(arch_addr[2:0]);
            GRP_LOCAL:  phys_idx = PAW'(LOC_BASE)  + PAW'({cwp, arch_addr[2:0]});
            GRP_IN:     phys_idx = PAW'(BANK_BASE) + PAW'({cwp, arch_addr[2:0]});
            default:    phys_idx = PAW'(BANK_BASE) + PAW'({out_bank, arch_addr[2:0]});
        endcase
    end
endmodule

// File: rtl/wrf_storage.sv
// Flat flop array with two combinational read ports and one write port.
// Entry 0 is never written and resets to zero, so it always reads zero.
module wrf_storage #(
    parameter int DW    = 32,
    parameter int NPHYS = 136,
    parameter int PAW   = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [PAW-1:0] waddr,
    input  logic [DW-1:0]  wdata,
    input  logic [PAW-1:0] raddr_a,
    output logic [DW-1:0]  rdata_a,
    input  logic [PAW-1:0] raddr_b,
    output logic [DW-1:0]  rdata_b
);
    logic [DW-1:0] mem [NPHYS];

    // Clear all entries on reset; write any entry except the zero slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPHYS; i++) mem[i] <= '0;
        end else if (we && (waddr != '0)) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/wrf_window_ctrl.sv
// Holds the current window pointer and the invalid-window mask, and decides
// whether a save or restore moves the pointer or raises a trap pulse.
// Assumes a save and restore in the same cycle cancel each other.
module wrf_window_ctrl #(
    parameter int NWIN = 8,
    parameter int CW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            save_i,
    input  logic            restore_i,
    input  logic            mask_we,
    input  logic [NWIN-1:0] mask_wdata,
    output logic [CW-1:0]   cwp_o,
    output logic [NWIN-1:0] wim_o,
    output logic            ovf_o,
    output logic            unf_o,
    output logic [CW-1:0]   trap_win_o
);
    logic [CW-1:0]   cwp_q, cwp_dn, cwp_up, trap_win_q;
    logic [NWIN-1:0] wim_q;
    logic            ovf_q, unf_q;
    logic            do_save, do_restore, hit_dn, hit_up;

    assign do_save    = save_i & ~restore_i;
    assign do_restore = restore_i & ~save_i;
    assign cwp_dn     = cwp_q - CW'(1);
    assign cwp_up     = cwp_q + CW'(1);
    assign hit_dn     = wim_q[cwp_dn];
    assign hit_up     = wim_q[cwp_up];

    // Move the pointer when the target window is valid.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cwp_q <= CW'(NWIN - 1);
        else if (do_save && !hit_dn)   cwp_q <= cwp_dn;
        else if (do_restore && !hit_up) cwp_q <= cwp_up;
    end

    // Load a new invalid-window mask.
    always_ff @(posedge clk) begin
        if (!rst_n)       wim_q <= NWIN'(1);
        else if (mask_we) wim_q <= mask_wdata;
    end

    // Register one-cycle trap pulses and the offending window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q      <= 1'b0;
            unf_q      <= 1'b0;
            trap_win_q <= '0;
        end else begin
            ovf_q <= do_save & hit_dn;
            unf_q <= do_restore & hit_up;
            if (do_save && hit_dn)         trap_win_q <= cwp_dn;
            else if (do_restore && hit_up) trap_win_q <= cwp_up;
        end
    end

    assign cwp_o      = cwp_q;
    assign wim_o      = wim_q;
    assign ovf_o      = ovf_q;
    assign unf_o      = unf_q;
    assign trap_win_o = trap_win_q;
endmodule

// File: rtl/win_regfile.sv
// Top of the overlapping windowed register file: a ring of NWIN windows with
// shared globals, private locals and in/out banks shared between neighbours.
// Assumes NWIN is a power of two between 2 and 32.
module win_regfile #(
    parameter int NWIN = 8,
    parameter int DW   = 32,
    localparam int CW  = $clog2(NWIN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            save_i,
    input  logic            restore_i,
    input  logic [4:0]      rd_a_addr,
    output logic [DW-1:0]   rd_a_data,
    input  logic [4:0]      rd_b_addr,
    output logic [DW-1:0]   rd_b_data,
    input  logic            wr_en,
    input  logic [4:0]      wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic            mask_wr_en,
    input  logic [NWIN-1:0] mask_wr_data,
    output logic [CW-1:0]   cwp_o,
    output logic            ovf_o,
    output logic            unf_o,
    output logic [CW-1:0]   trap_win_o
);
    localparam int NPHYS  = 8 + 16 * NWIN;
    localparam int PAW    = $clog2(NPHYS);
    localparam int NPORTS = 3;

    logic [CW-1:0]   cwp_q;
    logic [NWIN-1:0] wim_q;
    logic [4:0]      map_addr [NPORTS];
    logic [PAW-1:0]  map_phys [NPORTS];

    wrf_window_ctrl #(.NWIN(NWIN), .CW(CW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .save_i     (save_i),
        .restore_i  (restore_i),
        .mask_we    (mask_wr_en),
        .mask_wdata (mask_wr_data),
        .cwp_o      (cwp_q),
        .wim_o      (wim_q),
        .ovf_o      (ovf_o),
        .unf_o      (unf_o),
        .trap_win_o (trap_win_o)
    );

    assign map_addr[0] = rd_a_addr;
    assign map_addr[1] = rd_b_addr;
    assign map_addr[2] = wr_addr;

    // One address mapper per register port.
    for (genvar p = 0; p < NPORTS; p++) begin : g_map
        wrf_addr_map #(.NWIN(NWIN), .CW(CW), .PAW(PAW)) u_map (
            .cwp       (cwp_q),
            .arch_addr (map_addr[p]),
            .phys_idx  (map_phys[p])
        );
    end

    wrf_storage #(.DW(DW), .NPHYS(NPHYS), .PAW(PAW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_en),
        .waddr   (map_phys[2]),
        .wdata   (wr_data),
        .raddr_a (map_phys[0]),
        .rdata_a (rd_a_data),
        .raddr_b (map_phys[1]),
        .rdata_b (rd_b_data)
    );

    assign cwp_o = cwp_q;
endmodule

// File: rtl/wrf_checker.sv
// Cycle-by-cycle properties of the windowed register file, bound to the top.
module wrf_checker #(
    parameter int NWIN = 8,
    parameter int DW   = 32,
    localparam int CW  = $clog2(NWIN)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            save_i,
    input logic            restore_i,
    input logic [4:0]      rd_a_addr,
    input logic [DW-1:0]   rd_a_data,
    input logic [4:0]      rd_b_addr,
    input logic [DW-1:0]   rd_b_data,
    input logic [CW-1:0]   cwp_o,
    input logic [NWIN-1:0] wim_q,
    input logic            ovf_o,
    input logic            unf_o,
    input logic [CW-1:0]   trap_win_o
);
    logic [CW-1:0] cwp_m1, cwp_p1;
    assign cwp_m1 = cwp_o - CW'(1);
    assign cwp_p1 = cwp_o + CW'(1);

    a_r1_save_step: assert property (@(posedge clk) disable iff (!rst_n)
        (save_i && !restore_i && !wim_q[cwp_m1]) |=> (cwp_o == $past(cwp_m1) && !ovf_o));

    a_r2_restore_step: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_i && !save_i && !wim_q[cwp_p1]) |=> (cwp_o == $past(cwp_p1) && !unf_o));

    a_r3_both_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (save_i && restore_i) |=> (cwp_o == $past(cwp_o) && !ovf_o && !unf_o));

    a_r4_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (save_i && !restore_i && wim_q[cwp_m1]) |=>
        (ovf_o && trap_win_o == $past(cwp_m1) && cwp_o == $past(cwp_o)));

    a_r5_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_i && !save_i && wim_q[cwp_p1]) |=>
        (unf_o && trap_win_o == $past(cwp_p1) && cwp_o == $past(cwp_o)));

    a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ovf_o, unf_o}));

    a_r7_zero_port_a: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_addr == 5'd0) |-> (rd_a_data == '0));

    a_r7_zero_port_b: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_addr == 5'd0) |-> (rd_b_data == '0));
endmodule

bind win_regfile wrf_checker #(.NWIN(NWIN), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .save_i     (save_i),
    .restore_i  (restore_i),
    .rd_a_addr  (rd_a_addr),
    .rd_a_data  (rd_a_data),
    .rd_b_addr  (rd_b_addr),
    .rd_b_data  (rd_b_data),
    .cwp_o      (cwp_o),
    .wim_q      (wim_q),
    .ovf_o      (ovf_o),
    .unf_o      (unf_o),
    .trap_win_o (trap_win_o)
);

// File: tb/win_regfile_tb_top.sv
// Sweeping bench for the windowed register file, with a bench-side model.
module win_regfile_tb_top;
    localparam int NW = 8;
    localparam int DW = 32;
    localparam int CW = $clog2(NW);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          save_i = 0, restore_i = 0, wr_en = 0, mask_wr_en = 0;
    logic [4:0]    rd_a_addr = 0, rd_b_addr = 0, wr_addr = 0;
    logic [DW-1:0] wr_data = 0, rd_a_data, rd_b_data;
    logic [NW-1:0] mask_wr_data = 0;
    logic [CW-1:0] cwp_o, trap_win_o;
    logic          ovf_o, unf_o;

    win_regfile #(.NWIN(NW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .save_i(save_i), .restore_i(restore_i),
        .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
        .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
        .cwp_o(cwp_o), .ovf_o(ovf_o), .unf_o(unf_o), .trap_win_o(trap_win_o)
    );

    int n_chk = 0, n_fail = 0;
    logic [DW-1:0] m_glob [8];
    logic [DW-1:0] m_loc  [NW][8];
    logic [DW-1:0] m_bank [NW][8];
    int            e_cwp;
    logic [NW-1:0] e_mask;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] m_rd(input int w, input int r);
        case (r / 8)
            0:       return (r == 0) ? '0 : m_glob[r % 8];
            1:       return m_bank[(w + NW - 1) % NW][r % 8];
            2:       return m_loc[w][r % 8];
            default: return m_bank[w][r % 8];
        endcase
    endfunction

    task automatic m_wr(input int w, input int r, input logic [DW-1:0] v);
        case (r / 8)
            0:       if (r != 0) m_glob[r % 8] = v;
            1:       m_bank[(w + NW - 1) % NW][r % 8] = v;
            2:       m_loc[w][r % 8] = v;
            default: m_bank[w][r % 8] = v;
        endcase
    endtask

    function automatic string grp_tag(input int r);
        if (r == 0)  return "R7";
        if (r < 8)   return "R6";
        if (r < 16)  return "R8";
        if (r < 24)  return "R9";
        return "R8";
    endfunction

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    // Read r on port A and 31-r on port B, compare with the model.
    task automatic rd_chk(input int r, input string tag);
        string ta, tb;
        rd_a_addr = 5'(r);
        rd_b_addr = 5'(31 - r);
        #1;
        ta = (tag == "") ? grp_tag(r) : tag;
        tb = (tag == "") ? grp_tag(31 - r) : tag;
        check(ta, rd_a_data, m_rd(e_cwp, r));
        check(tb, rd_b_data, m_rd(e_cwp, 31 - r));
    endtask

    task automatic wr(input int r, input logic [DW-1:0] v);
        wr_en = 1; wr_addr = 5'(r); wr_data = v;
        step();
        wr_en = 0;
        m_wr(e_cwp, r, v);
    endtask

    // Window operation with optional same-cycle mask write; predicts the result.
    task automatic wop(input bit s, input bit rs, input bit mw, input logic [NW-1:0] mv);
        int tgt;
        bit trap;
        string tag;
        tgt = s ? (e_cwp + NW - 1) % NW : (e_cwp + 1) % NW;
        trap = (s ^ rs) && e_mask[tgt];
        if (s && rs)      tag = "R3";
        else if (s)       tag = trap ? "R4" : "R1";
        else if (rs)      tag = trap ? "R5" : "R2";
        else              tag = "R12";
        if (mw && (s ^ rs)) tag = {tag, "/R12"};
        save_i = s; restore_i = rs; mask_wr_en = mw; mask_wr_data = mv;
        step();
        save_i = 0; restore_i = 0; mask_wr_en = 0;
        if ((s ^ rs) && !trap) e_cwp = tgt;
        if (mw) e_mask = mv;
        check(tag, 32'(cwp_o), 32'(e_cwp));
        check(tag, 32'(ovf_o), 32'(trap && s));
        check(tag, 32'(unf_o), 32'(trap && rs));
        if (trap) begin
            check(tag, 32'(trap_win_o), 32'(tgt));
            step();
            check(tag, 32'({ovf_o, unf_o}), 32'd0);
        end
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) m_glob[i] = '0;
        for (int w = 0; w < NW; w++)
            for (int i = 0; i < 8; i++) begin
                m_loc[w][i] = '0;
                m_bank[w][i] = '0;
            end
        e_cwp = NW - 1;
        e_mask = NW'(1);

        repeat (3) @(posedge clk);
        #2 rst_n = 1;

        // R11: reset state
        check("R11", 32'(cwp_o), 32'(NW - 1));
        check("R11", 32'({ovf_o, unf_o}), 32'd0);
        for (int r = 0; r < 32; r++) rd_chk(r, "R11");

        // R1/R4: save down the ring until the invalid window traps
        for (int i = 0; i < NW; i++) wop(1, 0, 0, '0);
        // R2/R5: restore up the ring until the invalid window traps
        for (int i = 0; i < NW; i++) wop(0, 1, 0, '0);
        // R3: both strobes at once
        wop(1, 1, 0, '0);

        // R12: clear the mask so every window is reachable
        wop(0, 0, 1, '0);

        // R6/R7/R8/R9: write every register in every window, then read all back
        for (int k = 0; k < NW; k++) begin
            for (int r = 0; r < 32; r++) wr(r, {8'(k), 8'(r), 16'hA5C3});
            wop(1, 0, 0, e_mask);
        end
        for (int k = 0; k < NW; k++) begin
            for (int r = 0; r < 32; r++) rd_chk(r, "");
            wop(0, 1, 0, e_mask);
        end

        // R8: an out written before a save appears as the in after it
        wr(11, 32'hDEAD0003);
        wop(1, 0, 0, e_mask);
        rd_chk(27, "R8");
        // R9: a local written here is not seen after a restore
        wr(18, 32'hBEEF0002);
        wop(0, 1, 0, e_mask);
        rd_chk(18, "R9");
        // R7: write to register 0 is discarded
        wr(0, 32'hFFFF_FFFF);
        rd_chk(0, "R7");

        // R10: same-cycle read returns the old value, new value after the edge
        rd_a_addr = 5'd17;
        wr_en = 1; wr_addr = 5'd17; wr_data = 32'h1234_5678;
        #1;
        check("R10", rd_a_data, m_rd(e_cwp, 17));
        step();
        wr_en = 0;
        m_wr(e_cwp, 17, 32'h1234_5678);
        #1;
        check("R10", rd_a_data, 32'h1234_5678);

        // R12: save with a same-cycle mask write uses the old mask
        wop(1, 0, 1, NW'(1) << ((e_cwp + NW - 1) % NW));
        wop(1, 0, 0, e_mask);
        wop(0, 1, 0, e_mask);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule